// File: doc/BRIEF.md
# Receive Packet Buffer with Abort and Sticky Discard

This block holds received network packets for one port between a packet writer on the line side and a 32-bit host read port. Both sides run on a single system clock, and every input is sampled on its rising edge. The writer presents one word per cycle, with a start marker on the first word of a packet and an end marker on the last. A packet becomes visible to the host only after its last word is stored. Until then the words stay speculative and can be rolled back.

Two inputs throw away the packet that is partly stored. The abort input drops it quietly, and the buffer then ignores words until the next start marker. The receive-error input also drops it, and it sets a sticky discard flag. While the flag is set the buffer loads no new packets, and it stays set until the host pulses the clear input. A packet that would overrun the storage is handled as a receive error. The flag is presented together with an output-enable that follows the host's interrupt-enable input, so a pad wrapper can tri-state the flag line.

Top module: `rx_pkt_buf`

## Requirements
- R1: A word with `wrValid=1` and `wrSop=1` opens a packet. The packet stays invisible to the host (`rdEmpty` stays 1 if nothing else is committed) until its word with `wrEop=1` is sampled. One clock edge after that word is sampled, `rdEmpty` is 0.
- R2: When `rdEn=1` is sampled while `rdEmpty=0`, the next cycle shows `rdValid=1` with the oldest committed word on `rdData`. `rdEop` is 1 exactly on the last word of each packet, and packets come out in arrival order. When `rdEn=1` is sampled while `rdEmpty=1`, the next cycle shows `rdValid=0`.
- R3: `wrAbort=1` discards every word of the open packet, including any word presented in the same cycle. Committed packets are not affected.
- R4: A word without `wrSop` is ignored when no packet is open, including after an abort. A word with `wrSop` that arrives while a packet is open discards the partial packet and starts a new one.
- R5: `wrError=1` discards the open packet, and `discardFlag` reads 1 from the next cycle on.
- R6: `discardFlag` stays 1 until it is cleared. While it is 1, words are not stored, including start words.
- R7: When `clrErr=1` is sampled, `discardFlag` is 0 in the next cycle, unless an error occurs in that same cycle, in which case the flag stays 1.
- R8: The buffer holds `DEPTH` words (default 16, a power of two). A packet of exactly `DEPTH` words fits. A word that would exceed `DEPTH` stored words, counting the open packet, is handled as a receive error: the packet is dropped and `discardFlag` is set. This includes a start word that arrives while committed words fill the buffer.
- R9: `discardOe` equals the value of `intEn` sampled on the previous clock edge.
- R10: While `rstN=0`: `rdEmpty=1`, `rdValid=0`, `discardFlag=0` and `discardOe=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Writer word valid |
| wrData | input | 32 | Writer data word |
| wrSop | input | 1 | First word of a packet |
| wrEop | input | 1 | Last word of a packet |
| wrAbort | input | 1 | Drop the open packet, then wait for the next start word |
| wrError | input | 1 | Receive error: drop the open packet and set the discard flag |
| rdEn | input | 1 | Host read request |
| rdData | output | 32 | Read word, valid while rdValid is 1 |
| rdEop | output | 1 | Read word is the last word of its packet |
| rdValid | output | 1 | rdData and rdEop hold a word popped on the previous edge |
| rdEmpty | output | 1 | No committed words are available |
| clrErr | input | 1 | Clear the sticky discard flag |
| intEn | input | 1 | Interrupt enable, drives the flag output-enable |
| discardFlag | output | 1 | Sticky flag: a packet was dropped because of an error |
| discardOe | output | 1 | Output enable for the discard flag line |

## Verification
The embedded assertions check, on every cycle, the behaviour that can be stated as a property:
- the flag sets after an error, stays set, and clears after a clear;
- no word is stored while the flag is set;
- `rdEmpty` cannot fall without a commit;
- committed occupancy stays within `DEPTH`;
- a rollback returns the speculative pointer to the committed one;
- the output-enable tracks `intEn`.

Only the directed scenarios can show the things that need whole packets:
- that the data read back is correct, with the right end markers and in arrival order;
- that aborted, errored and restarted packets leave no trace in the read stream;
- that a packet of exactly `DEPTH` words fits while a longer one does not;
- that a start word is refused while the buffer is full of committed packets.

// File: rtl/rx_pkt_buf_pkg.sv
package rx_pkt_buf_pkg;

  // Strobes from the write control to the storage datapath.
  typedef struct packed {
    logic startPkt;   // store word at committed pointer, open new packet
    logic appendWord; // store word at speculative pointer
    logic commit;     // make the stored packet visible (with start/append)
    logic rollback;   // speculative pointer returns to committed pointer
  } wrStrobe_t;

endpackage

// File: rtl/rx_pkt_ctl.sv
module rx_pkt_ctl
  import rx_pkt_buf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrValid,
  input  logic      wrSop,
  input  logic      wrEop,
  input  logic      wrAbort,
  input  logic      wrError,
  input  logic      clrErr,
  input  logic      intEn,
  input  logic      fullAtCommit,
  input  logic      fullAtSpec,
  output wrStrobe_t strb,
  output logic      discardFlag,
  output logic      discardOe
);

  logic inPkt;
  logic inPktNext;
  logic setErr;

  always_comb begin
    strb      = '0;
    setErr    = 1'b0;
    inPktNext = inPkt;
    if (wrAbort || wrError) begin
      strb.rollback = 1'b1;
      setErr        = wrError;
      inPktNext     = 1'b0;
    end else if (wrValid && wrSop && !discardFlag) begin
      if (fullAtCommit) begin
        strb.rollback = 1'b1;
        setErr        = 1'b1;
        inPktNext     = 1'b0;
      end else begin
        strb.startPkt = 1'b1;
        strb.commit   = wrEop;
        inPktNext     = !wrEop;
      end
    end else if (wrValid && !wrSop && inPkt) begin
      if (fullAtSpec) begin
        strb.rollback = 1'b1;
        setErr        = 1'b1;
        inPktNext     = 1'b0;
      end else begin
        strb.appendWord = 1'b1;
        strb.commit     = wrEop;
        inPktNext       = !wrEop;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt       <= 1'b0;
      discardFlag <= 1'b0;
      discardOe   <= 1'b0;
    end else begin
      inPkt     <= inPktNext;
      discardOe <= intEn;
      if (setErr)
        discardFlag <= 1'b1;
      else if (clrErr)
        discardFlag <= 1'b0;
    end
  end

  // R5
  err_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrError |=> discardFlag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    discardFlag && !clrErr |=> discardFlag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    discardFlag && clrErr && !wrError |=> !discardFlag);

  // R6
  no_load_while_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    discardFlag |-> !strb.startPkt && !strb.appendWord);

  // R6
  flag_no_open_pkt_chk: assert property (@(posedge clk) disable iff (!rstN)
    discardFlag |-> !inPkt);

  // R9
  oe_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    intEn |=> discardOe);

  // R9
  oe_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |=> !discardOe);

endmodule

// File: rtl/rx_pkt_store.sv
module rx_pkt_store
  import rx_pkt_buf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEop,
  input  logic              rdEn,
  output logic              fullAtCommit,
  output logic              fullAtSpec,
  output logic              rdEmpty,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEop
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [DATA_W:0] mem [DEPTH];

  logic [PW-1:0] rdPtr;
  logic [PW-1:0] commitPtr;
  logic [PW-1:0] specPtr;
  logic [PW-1:0] commitUsed;
  logic [PW-1:0] specUsed;
  logic [AW-1:0] wrAddr;
  logic          wrStore;
  logic          pop;

  assign commitUsed   = commitPtr - rdPtr;
  assign specUsed     = specPtr - rdPtr;
  assign fullAtCommit = (commitUsed == DEPTH_P);
  assign fullAtSpec   = (specUsed == DEPTH_P);
  assign rdEmpty      = (commitPtr == rdPtr);
  assign pop          = rdEn && !rdEmpty;
  assign wrStore      = strb.startPkt || strb.appendWord;
  assign wrAddr       = strb.startPkt ? commitPtr[AW-1:0] : specPtr[AW-1:0];

  always_ff @(posedge clk) begin
    if (wrStore)
      mem[wrAddr] <= {wrEop, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitPtr <= '0;
      specPtr   <= '0;
    end else if (strb.rollback) begin
      specPtr <= commitPtr;
    end else if (strb.startPkt) begin
      specPtr <= commitPtr + PW'(1);
      if (strb.commit)
        commitPtr <= commitPtr + PW'(1);
    end else if (strb.appendWord) begin
      specPtr <= specPtr + PW'(1);
      if (strb.commit)
        commitPtr <= specPtr + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      rdEop   <= 1'b0;
    end else begin
      rdValid <= pop;
      if (pop) begin
        rdPtr  <= rdPtr + PW'(1);
        rdData <= mem[rdPtr[AW-1:0]][DATA_W-1:0];
        rdEop  <= mem[rdPtr[AW-1:0]][DATA_W];
      end
    end
  end

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitUsed <= DEPTH_P && specUsed <= DEPTH_P && specUsed >= commitUsed);

  // R3
  rollback_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rollback |=> specPtr == commitPtr);

  // R1
  hidden_until_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEmpty && !strb.commit |=> rdEmpty);

  // R2
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && rdEmpty |=> !rdValid);

endmodule

// File: rtl/rx_pkt_buf.sv
module rx_pkt_buf
  import rx_pkt_buf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrSop,
  input  logic              wrEop,
  input  logic              wrAbort,
  input  logic              wrError,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEop,
  output logic              rdValid,
  output logic              rdEmpty,
  input  logic              clrErr,
  input  logic              intEn,
  output logic              discardFlag,
  output logic              discardOe
);

  wrStrobe_t strb;
  logic      fullAtCommit;
  logic      fullAtSpec;

  rx_pkt_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .wrValid      (wrValid),
    .wrSop        (wrSop),
    .wrEop        (wrEop),
    .wrAbort      (wrAbort),
    .wrError      (wrError),
    .clrErr       (clrErr),
    .intEn        (intEn),
    .fullAtCommit (fullAtCommit),
    .fullAtSpec   (fullAtSpec),
    .strb         (strb),
    .discardFlag  (discardFlag),
    .discardOe    (discardOe)
  );

  rx_pkt_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (wrData),
    .wrEop        (wrEop),
    .rdEn         (rdEn),
    .fullAtCommit (fullAtCommit),
    .fullAtSpec   (fullAtSpec),
    .rdEmpty      (rdEmpty),
    .rdValid      (rdValid),
    .rdData       (rdData),
    .rdEop        (rdEop)
  );

endmodule

// File: tb/rx_pkt_buf_bench.sv
module rx_pkt_buf_bench;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        wrSop = 1'b0;
  logic        wrEop = 1'b0;
  logic        wrAbort = 1'b0;
  logic        wrError = 1'b0;
  logic        rdEn = 1'b0;
  logic        clrErr = 1'b0;
  logic        intEn = 1'b0;
  logic [31:0] rdData;
  logic        rdEop;
  logic        rdValid;
  logic        rdEmpty;
  logic        discardFlag;
  logic        discardOe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rx_pkt_buf #(.DATA_W(32), .DEPTH(DEPTH)) u_rx_pkt_buf (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wrSop(wrSop), .wrEop(wrEop), .wrAbort(wrAbort), .wrError(wrError),
    .rdEn(rdEn), .rdData(rdData), .rdEop(rdEop), .rdValid(rdValid),
    .rdEmpty(rdEmpty), .clrErr(clrErr), .intEn(intEn),
    .discardFlag(discardFlag), .discardOe(discardOe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are sampled there too.
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic quiet();
    wrValid = 0; wrSop = 0; wrEop = 0; wrAbort = 0; wrError = 0;
    rdEn = 0; clrErr = 0;
  endtask

  task automatic sendWord(input logic [31:0] d, input logic sop, input logic eop);
    wrValid = 1; wrData = d; wrSop = sop; wrEop = eop;
    cyc();
    quiet();
  endtask

  task automatic readWord(input string req, input logic [31:0] expD, input logic expEop);
    rdEn = 1;
    cyc();
    rdEn = 0;
    check({req, " rdValid"}, 64'(rdValid), 64'(1));
    check({req, " rdData"}, 64'(rdData), 64'(expD));
    check({req, " rdEop"}, 64'(rdEop), 64'(expEop));
  endtask

  task automatic testReset();
    check("R10 rdEmpty", 64'(rdEmpty), 64'(1));
    check("R10 rdValid", 64'(rdValid), 64'(0));
    check("R10 discardFlag", 64'(discardFlag), 64'(0));
    check("R10 discardOe", 64'(discardOe), 64'(0));
  endtask

  task automatic testSimplePacket();
    sendWord(32'hA000_0001, 1, 0);
    sendWord(32'hA000_0002, 0, 0);
    check("R1 hidden before eop", 64'(rdEmpty), 64'(1));
    sendWord(32'hA000_0003, 0, 1);
    check("R1 visible after eop", 64'(rdEmpty), 64'(0));
    sendWord(32'hB000_0001, 1, 1);
    readWord("R2 pkt A w0", 32'hA000_0001, 0);
    readWord("R2 pkt A w1", 32'hA000_0002, 0);
    readWord("R2 pkt A w2", 32'hA000_0003, 1);
    readWord("R2 pkt B w0", 32'hB000_0001, 1);
    check("R2 empty after drain", 64'(rdEmpty), 64'(1));
    rdEn = 1; cyc(); rdEn = 0;
    check("R2 no pop when empty", 64'(rdValid), 64'(0));
  endtask

  task automatic testAbort();
    sendWord(32'hC000_0001, 1, 1);
    sendWord(32'hD000_0001, 1, 0);
    sendWord(32'hD000_0002, 0, 0);
    wrAbort = 1; wrValid = 1; wrData = 32'hD000_0003; cyc(); quiet();
    sendWord(32'hD000_0004, 0, 0);
    sendWord(32'hD000_0005, 0, 1);
    sendWord(32'hE000_0001, 1, 0);
    sendWord(32'hE000_0002, 0, 1);
    readWord("R3 committed kept", 32'hC000_0001, 1);
    readWord("R4 new pkt after abort w0", 32'hE000_0001, 0);
    readWord("R4 new pkt after abort w1", 32'hE000_0002, 1);
    check("R3 aborted words absent", 64'(rdEmpty), 64'(1));
    check("R3 abort sets no flag", 64'(discardFlag), 64'(0));
  endtask

  task automatic testSopRestart();
    sendWord(32'hF000_0001, 1, 0);
    sendWord(32'hF000_0002, 0, 0);
    sendWord(32'h9000_0001, 1, 0);
    sendWord(32'h9000_0002, 0, 1);
    readWord("R4 restart w0", 32'h9000_0001, 0);
    readWord("R4 restart w1", 32'h9000_0002, 1);
    check("R4 partial dropped", 64'(rdEmpty), 64'(1));
  endtask

  task automatic testErrorFlag();
    sendWord(32'h5000_0001, 1, 0);
    wrError = 1; cyc(); quiet();
    check("R5 flag set", 64'(discardFlag), 64'(1));
    sendWord(32'h5000_0002, 0, 1);
    sendWord(32'h6000_0001, 1, 1);
    check("R6 no load while flagged", 64'(rdEmpty), 64'(1));
    check("R6 flag sticky", 64'(discardFlag), 64'(1));
    clrErr = 1; wrError = 1; cyc(); quiet();
    check("R7 clear with error keeps flag", 64'(discardFlag), 64'(1));
    clrErr = 1; cyc(); quiet();
    check("R7 clear", 64'(discardFlag), 64'(0));
    sendWord(32'h7000_0001, 1, 1);
    readWord("R7 load after clear", 32'h7000_0001, 1);
  endtask

  task automatic testOverflow();
    for (int i = 0; i <= DEPTH; i++)
      sendWord(32'h8000_0000 + i, (i == 0), 0);
    check("R8 overflow sets flag", 64'(discardFlag), 64'(1));
    check("R8 overflow pkt dropped", 64'(rdEmpty), 64'(1));
    clrErr = 1; cyc(); quiet();
    for (int i = 0; i < DEPTH; i++)
      sendWord(32'h4000_0000 + i, (i == 0), (i == DEPTH - 1));
    check("R8 full-size pkt committed", 64'(rdEmpty), 64'(0));
    check("R8 full-size pkt no flag", 64'(discardFlag), 64'(0));
    sendWord(32'h3000_0001, 1, 1);
    check("R8 sop into full sets flag", 64'(discardFlag), 64'(1));
    clrErr = 1; cyc(); quiet();
    for (int i = 0; i < DEPTH; i++)
      readWord("R8 full-size readback", 32'h4000_0000 + i, (i == DEPTH - 1));
    check("R8 drained", 64'(rdEmpty), 64'(1));
  endtask

  task automatic testOutputEnable();
    intEn = 1; cyc();
    check("R9 oe follows intEn high", 64'(discardOe), 64'(1));
    intEn = 0; cyc();
    check("R9 oe follows intEn low", 64'(discardOe), 64'(0));
  endtask

  initial begin
    quiet();
    rstN = 0;
    cyc(); cyc();
    testReset();
    rstN = 1;
    cyc();
    testSimplePacket();
    testAbort();
    testSopRestart();
    testErrorFlag();
    testOverflow();
    testOutputEnable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule